// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions. Each direction has its own storage, and its own controls pick one of three behaviours. When the pass control is high, the output copies the input with no clock delay. When pass is low and the direction's strobe does not rise, the stored word is held. When pass is low and the strobe rises, the input word is captured. The two ports are modelled as separate input, output and per-bit drive-enable vectors, not as true bidirectional pins.

The word is split into two 9-bit halves. Each half has its own active-low output enable, pass control and strobe in each direction, so the block can serve as two independent 9-bit transceivers. The parameter `TIE_HALVES` makes the half-0 controls govern the whole word, for use as one 18-bit transceiver.

The direction strobes are sampled on the block clock `clk`, and a rise is detected between two successive samples. A test-mode input hands the output data and drive enables to a boundary-test controller outside the block. While it is high, both stores stay frozen.

Top module: `bus_xcvr18`

## Requirements
- R1: With test mode low and a half's pass control high, that half's output equals the corresponding input slice within the same cycle.
- R2: With test mode low, pass low and no rise of the half's strobe (held steady at 0 or at 1), the half's output keeps its stored value whatever the input does.
- R3: With test mode low and pass low, a rise of the half's strobe (low at one `clk` edge, high at the next) stores the input present at the second edge, and the output shows it after that edge.
- R4: While pass is high the store follows the input at every `clk` edge. When pass then falls with no strobe rise, the output shows the input sampled at the last edge where pass was high.
- R5: If pass falls at the same `clk` edge at which a strobe rise is detected, the input at that edge is captured.
- R6: With test mode low, each half's 9 drive-enable bits are all 1 when its active-low enable is 0, and all 0 when it is 1.
- R7: The B-to-A direction behaves like A-to-B under its own controls, and neither direction's controls affect the other.
- R8: With `TIE_HALVES`=0, each 9-bit half (bits 8:0 = half 0, bits 17:9 = half 1) obeys only its own control bit (index 0 or 1).
- R9: With test mode high, the outputs equal the test data inputs and each half's enables equal its test-enable bit. Neither store changes, so on leaving test mode with pass low the pre-test word reappears.
- R10: While the asynchronous active-low reset is asserted, all drive enables are 0. Reset clears both stores to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 18 | Value seen on port A |
| aOut | output | 18 | Value driven onto port A |
| aOe | output | 18 | Per-bit drive enable of port A (0 = high impedance) |
| bIn | input | 18 | Value seen on port B |
| bOut | output | 18 | Value driven onto port B |
| bOe | output | 18 | Per-bit drive enable of port B (0 = high impedance) |
| abOeN | input | 2 | Active-low B drive enable, one bit per half |
| abLe | input | 2 | A-to-B pass control, one bit per half |
| abClk | input | 2 | A-to-B capture strobe, one bit per half |
| baOeN | input | 2 | Active-low A drive enable, one bit per half |
| baLe | input | 2 | B-to-A pass control, one bit per half |
| baClk | input | 2 | B-to-A capture strobe, one bit per half |
| testMode | input | 1 | Hands data and enables to the test inputs and freezes both stores |
| testAOut | input | 18 | Port A data used in test mode |
| testBOut | input | 18 | Port B data used in test mode |
| testAOe | input | 2 | Port A drive enable per half in test mode |
| testBOe | input | 2 | Port B drive enable per half in test mode |

## Verification
The hardest case to reach from the ports is the edge where pass falls and the strobe rises together. Pass has just kept the store following the input, so a wrong priority between hold and capture leaves the store looking correct. The stimulus holds the strobe low for a cycle and sets pass high with one word on the input. It then drops pass, raises the strobe and changes the input word, all in the same cycle, so only a real capture shows the new word. Test-mode entry and exit with pass low are also driven, together with strobe toggles during test mode. A second pass with a different word then shows whether the frozen store was disturbed.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Per-half strobes from a direction controller to its datapath
  typedef struct packed {
    logic pass;       // output follows input
    logic load;       // store takes input at this clk edge
    logic drive;      // port drive enable
    logic forceTest;  // data comes from test inputs
  } halfStrobe_t;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_HOLD    = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_TEST    = 2'd3
  } halfMode_e;

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import bus_xcvr_pkg::*;
#(
  parameter int NUM_HALVES = 2,
  parameter bit TIE_HALVES = 1'b0
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_HALVES-1:0]               oeN,
  input  logic [NUM_HALVES-1:0]               le,
  input  logic [NUM_HALVES-1:0]               stb,
  input  logic                                testMode,
  input  logic [NUM_HALVES-1:0]               testOe,
  output halfStrobe_t [NUM_HALVES-1:0]        strobes
);

  logic [NUM_HALVES-1:0] stbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbPrev <= '0;
    else       stbPrev <= stb;
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int SRC = TIE_HALVES ? 0 : h;
    halfMode_e mode;
    logic      stbRise;

    assign stbRise = stb[SRC] & ~stbPrev[SRC];

    always_comb begin
      if (testMode)      mode = MODE_TEST;
      else if (le[SRC])  mode = MODE_PASS;
      else if (stbRise)  mode = MODE_CAPTURE;
      else               mode = MODE_HOLD;
    end

    always_comb begin
      strobes[h].pass      = (mode == MODE_PASS);
      strobes[h].load      = (mode == MODE_PASS) || (mode == MODE_CAPTURE);
      strobes[h].forceTest = (mode == MODE_TEST);
      strobes[h].drive     = rstN & ((mode == MODE_TEST) ? testOe[h] : ~oeN[SRC]);
    end
  end

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import bus_xcvr_pkg::*;
#(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BUS_W-1:0]             dIn,
  input  logic [BUS_W-1:0]             testData,
  input  halfStrobe_t [NUM_HALVES-1:0] strobes,
  output logic [BUS_W-1:0]             dOut,
  output logic [BUS_W-1:0]             dOe
);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int LO = h * HALF_W;
    logic [HALF_W-1:0] held;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                held <= '0;
      else if (strobes[h].load) held <= dIn[LO +: HALF_W];
    end

    always_comb begin
      if (strobes[h].forceTest)  dOut[LO +: HALF_W] = testData[LO +: HALF_W];
      else if (strobes[h].pass)  dOut[LO +: HALF_W] = dIn[LO +: HALF_W];
      else                       dOut[LO +: HALF_W] = held;
    end

    assign dOe[LO +: HALF_W] = {HALF_W{strobes[h].drive}};
  end

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import bus_xcvr_pkg::*;
#(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  parameter bit TIE_HALVES = 1'b0,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BUS_W-1:0]      aIn,
  output logic [BUS_W-1:0]      aOut,
  output logic [BUS_W-1:0]      aOe,
  input  logic [BUS_W-1:0]      bIn,
  output logic [BUS_W-1:0]      bOut,
  output logic [BUS_W-1:0]      bOe,
  input  logic [NUM_HALVES-1:0] abOeN,
  input  logic [NUM_HALVES-1:0] abLe,
  input  logic [NUM_HALVES-1:0] abClk,
  input  logic [NUM_HALVES-1:0] baOeN,
  input  logic [NUM_HALVES-1:0] baLe,
  input  logic [NUM_HALVES-1:0] baClk,
  input  logic                  testMode,
  input  logic [BUS_W-1:0]      testAOut,
  input  logic [BUS_W-1:0]      testBOut,
  input  logic [NUM_HALVES-1:0] testAOe,
  input  logic [NUM_HALVES-1:0] testBOe
);

  halfStrobe_t [NUM_HALVES-1:0] abStrobes;
  halfStrobe_t [NUM_HALVES-1:0] baStrobes;

  xcvr_dir_ctrl #(.NUM_HALVES(NUM_HALVES), .TIE_HALVES(TIE_HALVES)) abCtrl (
    .clk(clk), .rstN(rstN), .oeN(abOeN), .le(abLe), .stb(abClk),
    .testMode(testMode), .testOe(testBOe), .strobes(abStrobes)
  );

  xcvr_dir_ctrl #(.NUM_HALVES(NUM_HALVES), .TIE_HALVES(TIE_HALVES)) baCtrl (
    .clk(clk), .rstN(rstN), .oeN(baOeN), .le(baLe), .stb(baClk),
    .testMode(testMode), .testOe(testAOe), .strobes(baStrobes)
  );

  xcvr_dir_path #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) abPath (
    .clk(clk), .rstN(rstN), .dIn(aIn), .testData(testBOut),
    .strobes(abStrobes), .dOut(bOut), .dOe(bOe)
  );

  xcvr_dir_path #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) baPath (
    .clk(clk), .rstN(rstN), .dIn(bIn), .testData(testAOut),
    .strobes(baStrobes), .dOut(aOut), .dOe(aOe)
  );

endmodule

// File: rtl/bus_xcvr18_chk.sv
module bus_xcvr18_chk #(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  parameter bit TIE_HALVES = 1'b0,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [BUS_W-1:0]      aIn,
  input logic [BUS_W-1:0]      aOut,
  input logic [BUS_W-1:0]      aOe,
  input logic [BUS_W-1:0]      bIn,
  input logic [BUS_W-1:0]      bOut,
  input logic [BUS_W-1:0]      bOe,
  input logic [NUM_HALVES-1:0] abOeN,
  input logic [NUM_HALVES-1:0] abLe,
  input logic [NUM_HALVES-1:0] abClk,
  input logic [NUM_HALVES-1:0] baOeN,
  input logic [NUM_HALVES-1:0] baLe,
  input logic [NUM_HALVES-1:0] baClk,
  input logic                  testMode,
  input logic [BUS_W-1:0]      testAOut,
  input logic [BUS_W-1:0]      testBOut,
  input logic [NUM_HALVES-1:0] testAOe,
  input logic [NUM_HALVES-1:0] testBOe
);

  // R10: no port drives during reset
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |-> (aOe == '0 && bOe == '0));

  // R9: test inputs own the outputs
  assert_test_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (aOut == testAOut && bOut == testBOut));

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_chk
    localparam int S  = TIE_HALVES ? 0 : g;
    localparam int LO = g * HALF_W;

    // R1: transparent A to B
    assert_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
      (!testMode && abLe[S]) |-> (bOut[LO +: HALF_W] == aIn[LO +: HALF_W]));

    // R7: transparent B to A
    assert_pass_ba_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!testMode && baLe[S]) |-> (aOut[LO +: HALF_W] == bIn[LO +: HALF_W]));

    // R2: no strobe rise, no pass -> stored word unchanged
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!testMode && !abLe[S] && !(abClk[S] && !$past(abClk[S])))
        ##1 (!testMode && !abLe[S]) |-> $stable(bOut[LO +: HALF_W]));

    // R3: strobe rise captures the input of that edge
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!testMode && !abLe[S] && abClk[S] && !$past(abClk[S]))
        ##1 (!testMode && !abLe[S]) |-> (bOut[LO +: HALF_W] == $past(aIn[LO +: HALF_W])));

    // R6: active-low enable per half
    assert_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
      !testMode |-> (bOe[LO +: HALF_W] == {HALF_W{~abOeN[S]}}
                  && aOe[LO +: HALF_W] == {HALF_W{~baOeN[S]}}));
  end

endmodule

bind bus_xcvr18 bus_xcvr18_chk #(
  .HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES), .TIE_HALVES(TIE_HALVES)
) chk (.*);

// File: tb/bus_xcvr18_test.sv
module bus_xcvr18_test;

  localparam int HW = 9;
  localparam int NH = 2;
  localparam int W  = HW * NH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0, testAOut = '0, testBOut = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;
  logic [NH-1:0] abOeN = '1, abLe = '0, abClk = '0;
  logic [NH-1:0] baOeN = '1, baLe = '0, baClk = '0;
  logic [NH-1:0] testAOe = '0, testBOe = '0;
  logic testMode = 1'b0;

  always #4 clk = ~clk;

  bus_xcvr18 uut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abOeN(abOeN), .abLe(abLe), .abClk(abClk),
    .baOeN(baOeN), .baLe(baLe), .baClk(baClk),
    .testMode(testMode), .testAOut(testAOut), .testBOut(testBOut),
    .testAOe(testAOe), .testBOe(testBOe)
  );

  typedef struct {
    logic [W-1:0] bOut, bOe, aOut, aOe;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0]  mAbHeld = '0, mBaHeld = '0;
  logic [NH-1:0] mAbPrev = '0, mBaPrev = '0;

  function automatic void modelDir(
    input  logic [W-1:0] din, input logic [NH-1:0] le, input logic [NH-1:0] stb,
    input  logic [NH-1:0] oeN, input logic [W-1:0] tData, input logic [NH-1:0] tOe,
    inout  logic [W-1:0] held, inout logic [NH-1:0] prev,
    output logic [W-1:0] eOut, output logic [W-1:0] eOe);
    for (int h = 0; h < NH; h++) begin
      if (!testMode && (le[h] || (stb[h] && !prev[h])))
        held[h*HW +: HW] = din[h*HW +: HW];
      if (testMode)   eOut[h*HW +: HW] = tData[h*HW +: HW];
      else if (le[h]) eOut[h*HW +: HW] = din[h*HW +: HW];
      else            eOut[h*HW +: HW] = held[h*HW +: HW];
      eOe[h*HW +: HW] = {HW{testMode ? tOe[h] : ~oeN[h]}};
    end
    prev = stb;
  endfunction

  // driver: called at a falling edge after inputs are set
  task automatic commit(input string tag);
    exp_t e;
    modelDir(aIn, abLe, abClk, abOeN, testBOut, testBOe, mAbHeld, mAbPrev, e.bOut, e.bOe);
    modelDir(bIn, baLe, baClk, baOeN, testAOut, testAOe, mBaHeld, mBaPrev, e.aOut, e.aOe);
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (bOut !== e.bOut || bOe !== e.bOe || aOut !== e.aOut || aOe !== e.aOe) begin
          fails++;
          $display("FAIL %s: bOut=%h bOe=%h aOut=%h aOe=%h expected bOut=%h bOe=%h aOut=%h aOe=%h",
                   e.tag, bOut, bOe, aOut, aOe, e.bOut, e.bOe, e.aOut, e.aOe);
        end
      end
    end
  end

  task automatic checkNow(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    abOeN = 2'b00; baOeN = 2'b00;
    #3;
    checkNow("R10 reset bOe", bOe, '0);
    checkNow("R10 reset aOe", aOe, '0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    abOeN = 2'b11; baOeN = 2'b11;
    aIn = 18'h155AA; bIn = 18'h0F0F0;
    commit("R10 store cleared, R6 enables off");
    abOeN = 2'b00; baOeN = 2'b00;
    commit("R10 store zero, R6 enables on");

    // R1 transparent
    abLe = 2'b11; baLe = 2'b11;
    for (int i = 0; i < 4; i++) begin
      aIn = W'($urandom); bIn = W'($urandom);
      commit("R1 transparent");
    end
    // R4: pass falls, input changes, no strobe rise
    abLe = 2'b00; baLe = 2'b00;
    aIn = 18'h3FFFF; bIn = 18'h00001;
    commit("R4 last transparent value held");
    // R2 hold with strobe steady low, then steady high
    for (int i = 0; i < 3; i++) begin
      aIn = W'($urandom); bIn = W'($urandom);
      commit("R2 hold strobe low");
    end
    abClk = 2'b11; baClk = 2'b11; aIn = 18'h12345; bIn = 18'h2AAAA;
    commit("R3 capture on rise");
    for (int i = 0; i < 3; i++) begin
      aIn = W'($urandom); bIn = W'($urandom);
      commit("R2 hold strobe high");
    end
    abClk = 2'b00; baClk = 2'b00; aIn = 18'h00777;
    commit("R2 hold on strobe fall");
    // R5: pass falls together with strobe rise
    abLe = 2'b11; baLe = 2'b11; aIn = 18'h11111; bIn = 18'h22222;
    commit("R5 setup transparent");
    abLe = 2'b00; baLe = 2'b00; abClk = 2'b11; baClk = 2'b11;
    aIn = 18'h2DEAD; bIn = 18'h1BEEF;
    commit("R5 coincident capture");
    aIn = 18'h00000; bIn = 18'h3FFFF;
    commit("R5 captured value kept");
    abClk = 2'b00; baClk = 2'b00;
    commit("R2 strobe return low");
    // R8 half independence
    abLe = 2'b01; abOeN = 2'b10; baLe = 2'b10; baOeN = 2'b01;
    aIn = 18'h3C0F0; bIn = 18'h0A5A5;
    commit("R8 halves independent");
    abLe = 2'b00; abClk = 2'b10; aIn = 18'h15555;
    commit("R8 capture upper half only");
    abClk = 2'b00; abOeN = 2'b00; baLe = 2'b00; baOeN = 2'b00;
    commit("R8 halves hold");
    // R9 test mode
    testMode = 1'b1; testAOut = 18'h2F00F; testBOut = 18'h1ABCD;
    testAOe = 2'b10; testBOe = 2'b01;
    abLe = 2'b11; abClk = 2'b11; baClk = 2'b11; aIn = 18'h3FFFF;
    commit("R9 test override");
    abLe = 2'b00; abClk = 2'b00; baLe = 2'b11;
    testAOe = 2'b01; testBOe = 2'b10;
    commit("R9 test override second");
    baLe = 2'b00; baClk = 2'b00; testMode = 1'b0;
    commit("R9 store frozen in test");
    // R7 random both directions
    for (int i = 0; i < 300; i++) begin
      abLe = NH'($urandom); abClk = NH'($urandom); abOeN = NH'($urandom);
      baLe = NH'($urandom); baClk = NH'($urandom); baOeN = NH'($urandom);
      aIn = W'($urandom); bIn = W'($urandom);
      commit("R7 random controls");
    end
    // R10 mid-run reset
    abLe = 2'b00; baLe = 2'b00; abClk = 2'b00; baClk = 2'b00;
    abOeN = 2'b00; baOeN = 2'b00;
    commit("R2 before reset");
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    checkNow("R10 async reset bOe", bOe, '0);
    checkNow("R10 async reset aOe", aOe, '0);
    checkNow("R10 async reset clears B store", bOut, '0);
    checkNow("R10 async reset clears A store", aOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    mAbHeld = '0; mBaHeld = '0; mAbPrev = '0; mBaPrev = '0;
    commit("R10 after reset");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule